// File: doc/BRIEF.md
# Interrupt Pending Register with Timer Match and Request Gating

This block keeps the set of pending interrupt lines for a processor core. Peripheral logic posts or withdraws single lines by index, and can wipe every line in one cycle. A software write port loads the two lowest lines directly. A line index outside the implemented range is rejected: an error flag is raised and that operation changes nothing.

The block also compares an externally kept count value against a compare value. A match with a nonzero count sets the line selected at run time by a 3-bit timer line input.

Two outputs go to the pipeline. The first is a raw "something is pending" flag. The second is a single interrupt request. It is raised only when at least one line is both pending and unmasked, global enable is set, and neither the error level nor the exception level is active. The request is combinational from the registered pending state. It is valid in the same cycle as the register, with no extra cycle of latency.

Top module: `irq_pend_gate`

## Requirements
- R1: A post with an in-range index n (post_idx, 4 bits, 0..7 valid) sets pending bit n on the next clock edge and leaves the other seven bits unchanged.
- R2: A withdraw with an in-range index n (clr_idx, 4 bits) clears pending bit n on the next clock edge and leaves the other bits unchanged.
- R3: clr_all zeroes all eight pending bits on the next clock edge.
- R4: A post or withdraw index of 8 to 15 drives idx_err high in the same cycle (combinationally) and that operation does not change any pending bit.
- R5: When cmp_val equals cnt_val and cnt_val is nonzero, pending bit tmr_line is set on the next edge. The other bits are unchanged.
- R6: When cmp_val equals cnt_val but both are zero, no pending bit is set.
- R7: irq_req is high exactly when glb_en is 1, err_lvl is 0, exc_lvl is 0, and (irq_mask AND pending) is nonzero. It follows changes in the mask and status inputs in the same cycle.
- R8: any_pend is high whenever any pending bit is set, whatever the mask and status inputs are.
- R9: Operations in one cycle apply in this order: clear-all, then the software write, then the withdraw, then the post and the timer set. A set therefore wins over a clear of the same bit.
- R10: sw_wr loads pending bits 1:0 from sw_data[1:0] on the next edge. Bits 7:2 are unchanged.
- R11: Reset (rst_n low) forces all pending bits to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| post_vld | input | 1 | Post request strobe |
| post_idx | input | 4 | Line index to post |
| clr_vld | input | 1 | Withdraw request strobe |
| clr_idx | input | 4 | Line index to withdraw |
| clr_all | input | 1 | Clear every pending line |
| sw_wr | input | 1 | Software write strobe for the two low lines |
| sw_data | input | 2 | Value loaded into pending bits 1:0 |
| cnt_val | input | 32 | Current count value |
| cmp_val | input | 32 | Compare value |
| tmr_line | input | 3 | Pending line the timer sets |
| irq_mask | input | 8 | Per-line enable mask |
| glb_en | input | 1 | Global interrupt enable |
| err_lvl | input | 1 | Error level active |
| exc_lvl | input | 1 | Exception level active |
| pend_o | output | 8 | Pending register |
| any_pend | output | 1 | At least one line pending |
| irq_req | output | 1 | Interrupt request to the pipeline |
| idx_err | output | 1 | Out-of-range index seen this cycle |

## Verification
The gating logic is driven with one pending line under a matching mask, a disjoint mask, and each of the three status inputs flipped in turn. This shows whether each condition blocks the request on its own, and it shows any_pend staying high while the request drops. The timer path is tried with a nonzero match, a match at zero count, and a mismatch. This separates the zero-count exclusion from a plain equality test. Same-cycle collisions of post, withdraw, clear-all and the software write are applied to one bit, to expose the wrong ordering. Indexes 8 and 15 are posted and withdrawn against a known register value, to show that nothing leaks into it.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int IRQ_LINES = 8;
  localparam int LINE_W    = $clog2(IRQ_LINES);
  localparam int IDX_W     = LINE_W + 1;
  localparam int SW_LINES  = 2;

  typedef logic [IRQ_LINES-1:0] pend_t;

  function automatic logic idx_ok(input logic [IDX_W-1:0] idx);
    return idx < IDX_W'(IRQ_LINES);
  endfunction

  function automatic pend_t line_dec(input logic [IDX_W-1:0] idx);
    pend_t v;
    v = '0;
    v[idx[LINE_W-1:0]] = 1'b1;
    return v;
  endfunction

  function automatic logic gate_ok(input logic en, input logic err, input logic exc,
                                   input pend_t mask, input pend_t pend);
    return en && !err && !exc && ((mask & pend) != '0);
  endfunction
endpackage

// File: rtl/irq_timer_match.sv
module irq_timer_match #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic [CNT_W-1:0] cmp_val,
  output logic             tmr_evt
);
  assign tmr_evt = (cnt_val == cmp_val) && (cnt_val != '0);

  // R6
  zero_count_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_val == '0) |-> !tmr_evt);
endmodule

// File: rtl/irq_pend_reg.sv
module irq_pend_reg
  import irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              post_vld,
  input  logic [IDX_W-1:0]  post_idx,
  input  logic              clr_vld,
  input  logic [IDX_W-1:0]  clr_idx,
  input  logic              clr_all,
  input  logic              sw_wr,
  input  logic [SW_LINES-1:0] sw_data,
  input  logic              tmr_evt,
  input  logic [LINE_W-1:0] tmr_line,
  output pend_t             pend_q,
  output logic              idx_err
);
  logic  post_go, clr_go;
  pend_t pend_d;

  assign post_go = post_vld && idx_ok(post_idx);
  assign clr_go  = clr_vld && idx_ok(clr_idx);
  assign idx_err = (post_vld && !idx_ok(post_idx)) || (clr_vld && !idx_ok(clr_idx));

  always_comb begin
    pend_d = pend_q;
    if (clr_all) pend_d = '0;
    if (sw_wr)   pend_d[SW_LINES-1:0] = sw_data;
    if (clr_go)  pend_d = pend_d & ~line_dec(clr_idx);
    if (post_go) pend_d = pend_d | line_dec(post_idx);
    if (tmr_evt) pend_d = pend_d | line_dec(IDX_W'(tmr_line));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  // R1
  post_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    post_go |=> pend_q[$past(post_idx[LINE_W-1:0])]);
  // R5
  timer_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_evt |=> pend_q[$past(tmr_line)]);
  // R3
  clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_all && !post_vld && !tmr_evt && !sw_wr) |=> (pend_q == '0));
  // R4
  bad_idx_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_err && !post_go && !clr_go && !clr_all && !sw_wr && !tmr_evt) |=> $stable(pend_q));
endmodule

// File: rtl/irq_gate.sv
module irq_gate
  import irq_pkg::*;
(
  input  pend_t pend,
  input  pend_t mask,
  input  logic  glb_en,
  input  logic  err_lvl,
  input  logic  exc_lvl,
  output logic  irq_req,
  output logic  any_pend
);
  assign irq_req  = gate_ok(glb_en, err_lvl, exc_lvl, mask, pend);
  assign any_pend = |pend;
endmodule

// File: rtl/irq_pend_gate.sv
module irq_pend_gate
  import irq_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 post_vld,
  input  logic [IDX_W-1:0]     post_idx,
  input  logic                 clr_vld,
  input  logic [IDX_W-1:0]     clr_idx,
  input  logic                 clr_all,
  input  logic                 sw_wr,
  input  logic [SW_LINES-1:0]  sw_data,
  input  logic [CNT_W-1:0]     cnt_val,
  input  logic [CNT_W-1:0]     cmp_val,
  input  logic [LINE_W-1:0]    tmr_line,
  input  logic [IRQ_LINES-1:0] irq_mask,
  input  logic                 glb_en,
  input  logic                 err_lvl,
  input  logic                 exc_lvl,
  output logic [IRQ_LINES-1:0] pend_o,
  output logic                 any_pend,
  output logic                 irq_req,
  output logic                 idx_err
);
  logic  tmr_evt;
  pend_t pend_q;

  irq_timer_match #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cmp_val(cmp_val), .tmr_evt(tmr_evt)
  );

  irq_pend_reg u_reg (
    .clk(clk), .rst_n(rst_n),
    .post_vld(post_vld), .post_idx(post_idx),
    .clr_vld(clr_vld), .clr_idx(clr_idx), .clr_all(clr_all),
    .sw_wr(sw_wr), .sw_data(sw_data),
    .tmr_evt(tmr_evt), .tmr_line(tmr_line),
    .pend_q(pend_q), .idx_err(idx_err)
  );

  irq_gate u_gate (
    .pend(pend_q), .mask(irq_mask), .glb_en(glb_en), .err_lvl(err_lvl),
    .exc_lvl(exc_lvl), .irq_req(irq_req), .any_pend(any_pend)
  );

  assign pend_o = pend_q;

  // R7
  req_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (glb_en && !err_lvl && !exc_lvl));
  // R8
  req_implies_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> any_pend);
  // R10
  sw_upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr && !post_vld && !clr_vld && !clr_all && !tmr_evt) |=>
      (pend_o[IRQ_LINES-1:SW_LINES] == $past(pend_o[IRQ_LINES-1:SW_LINES])));
endmodule

// File: tb/test_irq_pend_gate.sv
module test_irq_pend_gate;
  logic clk = 0, rst_n = 0;
  logic post_vld = 0, clr_vld = 0, clr_all = 0, sw_wr = 0;
  logic [3:0] post_idx = 0, clr_idx = 0;
  logic [1:0] sw_data = 0;
  logic [31:0] cnt_val = 1, cmp_val = 0;
  logic [2:0] tmr_line = 0;
  logic [7:0] irq_mask = 0;
  logic glb_en = 0, err_lvl = 0, exc_lvl = 0;
  logic [7:0] pend_o;
  logic any_pend, irq_req, idx_err;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  irq_pend_gate i_irq_pend_gate (
    .clk(clk), .rst_n(rst_n), .post_vld(post_vld), .post_idx(post_idx),
    .clr_vld(clr_vld), .clr_idx(clr_idx), .clr_all(clr_all), .sw_wr(sw_wr),
    .sw_data(sw_data), .cnt_val(cnt_val), .cmp_val(cmp_val), .tmr_line(tmr_line),
    .irq_mask(irq_mask), .glb_en(glb_en), .err_lvl(err_lvl), .exc_lvl(exc_lvl),
    .pend_o(pend_o), .any_pend(any_pend), .irq_req(irq_req), .idx_err(idx_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // inputs are set just after a falling edge; one rising edge later the
  // register holds the result, sampled at the next falling edge
  task automatic step();
    @(negedge clk);
    post_vld = 0; clr_vld = 0; clr_all = 0; sw_wr = 0;
  endtask

  task automatic load(input logic [7:0] v);
    clr_all = 1; step();
    for (int i = 0; i < 8; i++) if (v[i]) begin post_vld = 1; post_idx = 4'(i); step(); end
  endtask

  task automatic t_reset();
    chk("R11 reset pend", pend_o, 0);
    chk("R8 reset any", any_pend, 0);
  endtask

  task automatic t_post();
    post_vld = 1; post_idx = 3; step();
    chk("R1 post 3", pend_o, 8'h08);
    post_vld = 1; post_idx = 7; step();
    chk("R1 post 7", pend_o, 8'h88);
    chk("R8 any", any_pend, 1);
  endtask

  task automatic t_clear();
    load(8'hF0);
    clr_vld = 1; clr_idx = 5; step();
    chk("R2 clear 5", pend_o, 8'hD0);
    clr_all = 1; step();
    chk("R3 clear all", pend_o, 0);
    chk("R8 none", any_pend, 0);
  endtask

  task automatic t_oob();
    load(8'h21);
    post_vld = 1; post_idx = 8; #1;
    chk("R4 err post", idx_err, 1);
    step();
    chk("R4 post 8 inert", pend_o, 8'h21);
    clr_vld = 1; clr_idx = 15; #1;
    chk("R4 err clr", idx_err, 1);
    step();
    chk("R4 clr 15 inert", pend_o, 8'h21);
    #1 chk("R4 err idle", idx_err, 0);
  endtask

  task automatic t_timer();
    load(8'h00);
    tmr_line = 6; cmp_val = 5; cnt_val = 4; step();
    chk("R5 mismatch", pend_o, 0);
    cnt_val = 5; step(); cnt_val = 6;
    chk("R5 match sets 6", pend_o, 8'h40);
    cmp_val = 0; cnt_val = 0; tmr_line = 2; step(); step();
    chk("R6 zero count", pend_o, 8'h40);
    cnt_val = 1;
  endtask

  task automatic t_gate();
    load(8'h10);
    irq_mask = 8'h10; glb_en = 1; #1;
    chk("R7 req on", irq_req, 1);
    irq_mask = 8'hEF; #1;
    chk("R7 masked", irq_req, 0);
    chk("R8 any masked", any_pend, 1);
    irq_mask = 8'h10; err_lvl = 1; #1;
    chk("R7 err blocks", irq_req, 0);
    err_lvl = 0; exc_lvl = 1; #1;
    chk("R7 exc blocks", irq_req, 0);
    exc_lvl = 0; glb_en = 0; #1;
    chk("R7 en blocks", irq_req, 0);
    chk("R8 any status", any_pend, 1);
    glb_en = 1; #1;
    chk("R7 req back", irq_req, 1);
    glb_en = 0; irq_mask = 0;
    step();
  endtask

  task automatic t_priority();
    load(8'h00);
    post_vld = 1; post_idx = 4; clr_vld = 1; clr_idx = 4; clr_all = 1; step();
    chk("R9 post beats clears", pend_o, 8'h10);
    tmr_line = 1; cmp_val = 9; cnt_val = 9; sw_wr = 1; sw_data = 2'b00;
    clr_vld = 1; clr_idx = 1; step(); cnt_val = 1;
    chk("R9 timer beats sw and clr", pend_o, 8'h12);
  endtask

  task automatic t_sw();
    load(8'hA4);
    sw_wr = 1; sw_data = 2'b11; step();
    chk("R10 sw 11", pend_o, 8'hA7);
    sw_wr = 1; sw_data = 2'b10; step();
    chk("R10 sw 10", pend_o, 8'hA6);
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_post();
    t_clear();
    t_oob();
    t_timer();
    t_gate();
    t_priority();
    t_sw();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule